// File: doc/BRIEF.md
# Sandcastle timing pulse generator

This block turns a three-level sandcastle pulse into the timing strobes a colour decoder runs on. Two analog comparators in front of it have already sliced the sandcastle into a 2-bit level code. The block decodes that code into a burst gate, a line blanking pulse and a combined line-plus-field blanking pulse. It also keeps track of whether the field interval is in progress.

Several outputs are derived from those pulses. The automatic colour control measurement is gated by the burst gate and stays off for the whole field interval. A second burst gate is produced a fixed time later, for the SECAM identification path. A half-line-rate flip-flop advances on each line blanking edge, and the standard scanner can invert its phase with a one-cycle request. Per-channel blanking strobes for the two colour-difference outputs combine flyback blanking, the colour killer and, in SECAM mode, the line-alternate suppression of the channel that does not carry valid data on that line.

Every output except the delayed gate is registered once from the inputs. The delayed gate is decoded from counters, one clock after the burst gate it follows.

Top module: `sc_pulse_gen`

## Requirements
- R1: The level code `sc_lvl` decodes as follows: 3 gives burst gate, line blanking and combined blanking; 2 gives line blanking and combined blanking; 1 gives only combined blanking; 0 gives none. `burst_o`, `hblank_o` and `hvblank_o` show the decode one clock after the code is sampled.
- R2: `vblank_o` sets, one clock later, when code 1 is sampled. It stays set while the sampled code is non-zero and clears, one clock later, when code 0 is sampled.
- R3: `burst_dly_o` repeats each `burst_o` pulse with the same width, DLY = CLK_KHZ*DELAY_NS/1000000 cycles later (54 by default). This holds when the pulse width is at most DLY and successive pulses start at least 2*DLY cycles apart.
- R4: `acc_en_o` is high exactly when `burst_o` is high and `vblank_o` is low.
- R5: The half-line flag `hl_o` inverts in the cycle in which `hblank_o` rises. A one-cycle `hl_flip` request inverts it as well, with the same one-clock latency. When both happen on the same clock, the flag is left unchanged.
- R6: While `mode[1]` is 1 (code 2, NTSC, and code 3), `hl_o` is forced to 0 one clock later.
- R7: While `hvblank_o` is high, both `blank_by_o` and `blank_ry_o` are high in every mode.
- R8: When `colour_en` is sampled low, both blanking strobes are high one clock later.
- R9: In mode code 1 (SECAM), `blank_by_o` is also high when `hl_o` is 1, and `blank_ry_o` is also high when `hl_o` is 0. In modes 0, 2 and 3 there is no line-alternate blanking.
- R10: While `rst_n` is low, all outputs are 0 except the two blanking strobes, which are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_lvl | input | 2 | Sliced sandcastle level code (0 to 3) |
| mode | input | 2 | Standard: 0 PAL, 1 SECAM, 2 NTSC, 3 treated as NTSC |
| colour_en | input | 1 | Colour killer release; 0 blanks both channels |
| hl_flip | input | 1 | One-cycle request to invert the half-line phase |
| burst_o | output | 1 | Burst gate |
| burst_dly_o | output | 1 | Burst gate delayed by DLY cycles |
| hblank_o | output | 1 | Line blanking |
| hvblank_o | output | 1 | Combined line and field blanking |
| vblank_o | output | 1 | Field interval in progress |
| acc_en_o | output | 1 | Colour control measurement enable |
| hl_o | output | 1 | Half-line-rate flag |
| blank_by_o | output | 1 | Blanking strobe for the B-Y channel |
| blank_ry_o | output | 1 | Blanking strobe for the R-Y channel |

## Verification
The checker assumes that the sandcastle follows a real line structure. Each burst pulse lies inside line blanking, is no wider than DLY, and begins at least 2*DLY cycles after the previous one. The delayed-gate property depends on this. The stimulus builds every line from a randomly sized active part, a short line-blanking porch, a 3 to 10 cycle burst and a back porch, so bursts are always more than 120 cycles apart. Field-interval lines use code 1 in their active part. Mode and colour enable change only at line boundaries, and phase-invert requests arrive either at random inside the active part or, in directed lines, on the exact edge where line blanking begins.

// File: rtl/sc_pulse_gen.sv
module sc_pulse_gen #(
  parameter int CLK_KHZ  = 27000,
  parameter int DELAY_NS = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sc_lvl,
  input  logic [1:0] mode,
  input  logic       colour_en,
  input  logic       hl_flip,
  output logic       burst_o,
  output logic       burst_dly_o,
  output logic       hblank_o,
  output logic       hvblank_o,
  output logic       vblank_o,
  output logic       acc_en_o,
  output logic       hl_o,
  output logic       blank_by_o,
  output logic       blank_ry_o
);
  localparam int DLY = CLK_KHZ * DELAY_NS / 1000000;
  localparam int CW  = $clog2(2 * DLY + 2);
  localparam logic [CW-1:0] DLY_W = CW'(DLY);

  logic bk_n, hb_n, hv_n, vb_n, hl_n;
  logic secam, ntsc;

  assign secam = (mode == 2'd1);
  assign ntsc  = mode[1];
  assign bk_n  = (sc_lvl == 2'd3);
  assign hb_n  = sc_lvl[1];
  assign hv_n  = (sc_lvl != 2'd0);
  assign vb_n  = (sc_lvl == 2'd1) | (vblank_o & hv_n);
  assign hl_n  = ntsc ? 1'b0 : (hl_o ^ (hb_n & ~hblank_o) ^ hl_flip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_o    <= 1'b0;
      hblank_o   <= 1'b0;
      hvblank_o  <= 1'b0;
      vblank_o   <= 1'b0;
      acc_en_o   <= 1'b0;
      hl_o       <= 1'b0;
      blank_by_o <= 1'b1;
      blank_ry_o <= 1'b1;
    end else begin
      burst_o    <= bk_n;
      hblank_o   <= hb_n;
      hvblank_o  <= hv_n;
      vblank_o   <= vb_n;
      acc_en_o   <= bk_n & ~vb_n;
      hl_o       <= hl_n;
      blank_by_o <= hv_n | ~colour_en | (secam & hl_n);
      blank_ry_o <= hv_n | ~colour_en | (secam & ~hl_n);
    end
  end

  logic          bk_prev, run, in_w;
  logic [CW-1:0] dcnt, wlen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bk_prev <= 1'b0;
      run     <= 1'b0;
      in_w    <= 1'b0;
      dcnt    <= '0;
      wlen    <= '0;
    end else begin
      bk_prev <= burst_o;
      if (burst_o && !bk_prev) begin
        run  <= 1'b1;
        in_w <= 1'b1;
        dcnt <= CW'(1);
        wlen <= CW'(1);
      end else if (run) begin
        dcnt <= dcnt + CW'(1);
        if (in_w && burst_o) wlen <= wlen + CW'(1);
        if (!burst_o) in_w <= 1'b0;
        if (dcnt == DLY_W + wlen - CW'(1)) run <= 1'b0;
      end
    end
  end

  assign burst_dly_o = run && (dcnt >= DLY_W);
endmodule

// File: rtl/sc_pulse_gen_chk.sv
module sc_pulse_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sc_lvl,
  input logic [1:0] mode,
  input logic       colour_en,
  input logic       hl_flip,
  input logic       burst_o,
  input logic       burst_dly_o,
  input logic       hblank_o,
  input logic       hvblank_o,
  input logic       vblank_o,
  input logic       acc_en_o,
  input logic       hl_o,
  input logic       blank_by_o,
  input logic       blank_ry_o
);
  a_r1_code3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_lvl == 2'd3) |=> (burst_o && hblank_o && hvblank_o));
  a_r2_field_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_lvl == 2'd1) |=> vblank_o);
  a_r2_field_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_lvl == 2'd0) |=> !vblank_o);
  a_r3_dly_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_dly_o) |-> !burst_o);
  a_r4_acc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_o |-> !acc_en_o);
  a_r5_hl_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hblank_o) && !$past(hl_flip) && !$past(mode[1])) |-> (hl_o != $past(hl_o)));
  a_r6_ntsc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |=> !hl_o);
  a_r7_flyback: assert property (@(posedge clk) disable iff (!rst_n)
    hvblank_o |-> (blank_by_o && blank_ry_o));
  a_r8_killer: assert property (@(posedge clk) disable iff (!rst_n)
    !colour_en |=> (blank_by_o && blank_ry_o));
  a_r9_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && colour_en && sc_lvl == 2'd0) |=> (blank_by_o != blank_ry_o));
endmodule

bind sc_pulse_gen sc_pulse_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sc_lvl(sc_lvl), .mode(mode),
  .colour_en(colour_en), .hl_flip(hl_flip), .burst_o(burst_o),
  .burst_dly_o(burst_dly_o), .hblank_o(hblank_o), .hvblank_o(hvblank_o),
  .vblank_o(vblank_o), .acc_en_o(acc_en_o), .hl_o(hl_o),
  .blank_by_o(blank_by_o), .blank_ry_o(blank_ry_o)
);

// File: tb/sc_pulse_gen_bench.sv
module sc_pulse_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 27000;
  localparam int DELAY_NS   = 2000;
  localparam int D          = CLK_KHZ * DELAY_NS / 1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sc_lvl = 2'd0;
  logic [1:0] mode = 2'd0;
  logic colour_en = 1'b0;
  logic hl_flip = 1'b0;
  logic burst_o, burst_dly_o, hblank_o, hvblank_o, vblank_o;
  logic acc_en_o, hl_o, blank_by_o, blank_ry_o;

  sc_pulse_gen #(.CLK_KHZ(CLK_KHZ), .DELAY_NS(DELAY_NS)) u_sc_pulse_gen (
    .clk(clk), .rst_n(rst_n), .sc_lvl(sc_lvl), .mode(mode),
    .colour_en(colour_en), .hl_flip(hl_flip), .burst_o(burst_o),
    .burst_dly_o(burst_dly_o), .hblank_o(hblank_o), .hvblank_o(hvblank_o),
    .vblank_o(vblank_o), .acc_en_o(acc_en_o), .hl_o(hl_o),
    .blank_by_o(blank_by_o), .blank_ry_o(blank_ry_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  bit m_bk, m_hb, m_hv, m_vb, m_acc, m_hl, m_bby, m_bry;
  bit hist [0:D];

  task automatic chk(input string req, input string nm, input bit got, input bit exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, got, exp, $time);
    end
  endtask

  function automatic bit hl_next(bit hl, bit hb_old, bit hb_new, bit fl, bit ntsc);
    if (ntsc) return 1'b0;
    return hl ^ (hb_new & ~hb_old) ^ fl;
  endfunction

  task automatic model_reset();
    m_bk = 0; m_hb = 0; m_hv = 0; m_vb = 0; m_acc = 0; m_hl = 0;
    m_bby = 1; m_bry = 1;
    for (int i = 0; i <= D; i++) hist[i] = 1'b0;
  endtask

  task automatic model_step(input bit [1:0] l, input bit [1:0] md, input bit ce, input bit fl);
    bit nhb, nhv, nvb, nhl, sec;
    nhb = (l >= 2);
    nhv = (l != 0);
    nvb = (l == 1) || (m_vb && l != 0);
    nhl = hl_next(m_hl, m_hb, nhb, fl, md >= 2);
    sec = (md == 1);
    m_bk  = (l == 3);
    m_hb  = nhb;
    m_hv  = nhv;
    m_vb  = nvb;
    m_acc = m_bk && !nvb;
    m_hl  = nhl;
    m_bby = nhv || !ce || (sec && nhl);
    m_bry = nhv || !ce || (sec && !nhl);
    for (int i = D; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = m_bk;
  endtask

  task automatic compare_all();
    chk("R1", "burst", burst_o, m_bk);
    chk("R1", "hblank", hblank_o, m_hb);
    chk("R1", "hvblank", hvblank_o, m_hv);
    chk("R2", "vblank", vblank_o, m_vb);
    chk("R3", "burst_dly", burst_dly_o, hist[D]);
    chk("R4", "acc_en", acc_en_o, m_acc);
    chk(mode[1] ? "R6" : "R5", "hl", hl_o, m_hl);
    chk("R7/R8/R9", "blank_by", blank_by_o, m_bby);
    chk("R7/R8/R9", "blank_ry", blank_ry_o, m_bry);
  endtask

  task automatic step(input bit [1:0] l, input bit fl);
    sc_lvl = l;
    hl_flip = fl;
    @(posedge clk);
    model_step(l, mode, colour_en, fl);
    @(negedge clk);
    compare_all();
  endtask

  // edge_flip: raise hl_flip on the first line-blanking cycle (R5 cancel case)
  task automatic line(input bit field, input bit edge_flip, input int flip_prob);
    int act = 120 + $urandom % 80;
    int fp = 2 + $urandom % 4;
    int w = 3 + $urandom % 8;
    int bp = 3 + $urandom % 6;
    for (int i = 0; i < act; i++)
      step(field ? 2'd1 : 2'd0, (flip_prob > 0) && ($urandom % flip_prob == 0));
    for (int i = 0; i < fp; i++) step(2'd2, edge_flip && i == 0);
    for (int i = 0; i < w; i++) step(2'd3, 1'b0);
    for (int i = 0; i < bp; i++) step(2'd2, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit hl_before;
    void'($urandom(32'h5c17));
    model_reset();
    sc_lvl = 2'd3; colour_en = 1'b1; mode = 2'd1; hl_flip = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset values with active-looking inputs
    chk("R10", "burst", burst_o, 1'b0);
    chk("R10", "hvblank", hvblank_o, 1'b0);
    chk("R10", "acc_en", acc_en_o, 1'b0);
    chk("R10", "hl", hl_o, 1'b0);
    chk("R10", "burst_dly", burst_dly_o, 1'b0);
    chk("R10", "blank_by", blank_by_o, 1'b1);
    chk("R10", "blank_ry", blank_ry_o, 1'b1);
    sc_lvl = 2'd0; hl_flip = 1'b0;
    rst_n = 1'b1;

    // directed: PAL, colour on, plain lines
    mode = 2'd0; colour_en = 1'b1;
    repeat (3) line(1'b0, 1'b0, 0);
    // directed R9: SECAM alternate blanking on active part
    mode = 2'd1;
    repeat (3) begin
      line(1'b0, 1'b0, 0);
      step(2'd0, 1'b0);
      chk("R9", "one channel blanked", blank_by_o ^ blank_ry_o, 1'b1);
      chk("R9", "by follows hl", blank_by_o, hl_o);
    end
    // directed R5: flip on the blanking edge cancels the toggle
    hl_before = hl_o;
    line(1'b0, 1'b1, 0);
    chk("R5", "hl after cancelled edge", hl_o, hl_before);
    // directed R2/R4: field interval lines
    repeat (4) line(1'b1, 1'b0, 0);
    chk("R2", "vblank in field", vblank_o, 1'b1);
    line(1'b0, 1'b0, 0);
    // directed R6: NTSC holds hl low
    mode = 2'd2;
    repeat (2) line(1'b0, 1'b1, 50);
    chk("R6", "hl in ntsc", hl_o, 1'b0);
    // directed R8: colour off
    colour_en = 1'b0; mode = 2'd1;
    line(1'b0, 1'b0, 0);
    step(2'd0, 1'b0);
    chk("R8", "blank_by killer", blank_by_o, 1'b1);
    chk("R8", "blank_ry killer", blank_ry_o, 1'b1);

    // random lines
    for (int g = 0; g < 60; g++) begin
      mode = 2'($urandom % 4);
      colour_en = ($urandom % 4) != 0;
      for (int k = 0; k < 6; k++)
        line(($urandom % 5) == 0, ($urandom % 6) == 0, 150);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule